// File: doc/BRIEF.md
# Selectable-Latency Read Data Output Path

This block is the read-data output path of a synchronous DRAM. It sits between the sense-amplifier data and the output pins. A read command arrives with its sense-amplifier word and is captured on a clock edge. The word then reaches the output a fixed number of rising edges later: one, two or three. The path has two physical holding stages. Each stage can be skipped through a bypass. The selected latency decides which stages the data pass through: none, only the first, or both in turn.

The latency is loaded only by a mode-register command. That command carries a code expressed in half-cycle units: 2 means one cycle, 4 means two cycles and 6 means three cycles. Any other code, such as 3 (one and a half cycles) or 8 (four cycles), has no stage arrangement behind it. Such a code is refused and raises a sticky error flag. A valid command that arrives while a read is still held inside the stages is parked. It takes effect on the first edge at which both the capture stage and the two holding stages are empty.

Both the read input and the data output are valid-only streams. There is no ready signal on either side. A read presented with `rd_vld` high is always accepted. The output cannot be stalled, so a consumer must take every word in the cycle that `dout_vld` is high.

Top module: `lat_pipe`

## Requirements
- R1: After reset, `dout` is zero, `dout_vld` and `lat_err` are low, and the latency is three cycles. A later reset restores these values and clears `lat_err`.
- R2: The codes 2, 4 and 6 select a latency of 1, 2 or 3 cycles. With latency N, a read sampled on edge 0 makes its word appear on `dout`, with `dout_vld` high, right after edge N.
- R3: `dout_vld` is high for exactly one cycle per accepted read, in the cycle that its word is on `dout`. When `dout_vld` is low, `dout` is zero.
- R4: At every latency, reads on consecutive cycles produce words on consecutive cycles, in order, with no gaps.
- R5: A mode-register code other than 2, 4 or 6 leaves the active latency unchanged. It sets `lat_err`, which stays high until reset, even if valid codes follow.
- R6: A valid mode-register code that is sampled while a read occupies the internal stages is held. It applies on the first edge at which the internal stages are empty. A later valid code replaces the held one. Reads sampled before that edge keep the old latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld | input | 1 | Read command strobe (no back-pressure) |
| rd_data | input | DW | Sense-amplifier word for the read |
| mrs_vld | input | 1 | Mode-register command strobe |
| mrs_code | input | 4 | Latency code in half cycles (2, 4, 6 legal) |
| dout_vld | output | 1 | Output word valid, one cycle per read |
| dout | output | DW | Output data, zero when not valid |
| lat_err | output | 1 | Sticky flag: an unsupported code was seen |

## Verification
The hardest case to reach is a mode-register command that must wait. It has to land while a read is still inside the holding stages, and a further read must be issued before the stages drain. The stimulus sets latency three, issues a read, sends the new code on the next cycle, and then issues another read. That second read must still come out after three cycles, and only a read issued after the drain may use the new latency. A second sequence sends two valid codes into the same busy window. The later code must be the one that wins.

// File: rtl/lat_pkg.sv
package lat_pkg;
  // number of bypassable holding stages between capture and output
  parameter int unsigned NPIPE  = 2;
  localparam int unsigned LAT_MAX = NPIPE + 1;
  localparam int unsigned LAT_W   = $clog2(LAT_MAX + 1);
  localparam int unsigned CODE_W  = 4;

  // codes are latency in half-cycle units; only whole cycles map to stages
  function automatic logic code_legal(input logic [CODE_W-1:0] code);
    return (code[0] == 1'b0) && (code >= CODE_W'(2)) &&
           (32'(code) <= 2 * LAT_MAX);
  endfunction

  function automatic logic [LAT_W-1:0] code_to_lat(input logic [CODE_W-1:0] code);
    return LAT_W'(code >> 1);
  endfunction
endpackage

// File: rtl/lat_stage.sv
module lat_stage #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic          q_vld,
  output logic [DW-1:0] q_data
);
  // a disabled (bypassed) stage holds nothing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_data <= '0;
    end else if (en && in_vld) begin
      q_vld  <= 1'b1;
      q_data <= in_data;
    end else begin
      q_vld  <= 1'b0;
      q_data <= '0;
    end
  end
endmodule

// File: rtl/lat_cfg.sv
module lat_cfg
  import lat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_vld,
  input  logic [CODE_W-1:0] mrs_code,
  input  logic              idle,
  output logic [LAT_W-1:0]  act_lat,
  output logic              lat_err
);
  logic             ok;
  logic             take;
  logic             pend_vld;
  logic [LAT_W-1:0] pend_lat;

  assign ok   = code_legal(mrs_code);
  assign take = mrs_vld && ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_lat  <= LAT_W'(LAT_MAX);
      pend_vld <= 1'b0;
      pend_lat <= '0;
      lat_err  <= 1'b0;
    end else begin
      if (mrs_vld && !ok) lat_err <= 1'b1;
      if (take) begin
        if (idle) begin
          act_lat  <= code_to_lat(mrs_code);
          pend_vld <= 1'b0;
        end else begin
          pend_lat <= code_to_lat(mrs_code);
          pend_vld <= 1'b1;
        end
      end else if (pend_vld && idle) begin
        act_lat  <= pend_lat;
        pend_vld <= 1'b0;
      end
    end
  end

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_err |=> lat_err);
  // R5
  bad_code_keeps_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_vld && !ok && !pend_vld) |=> $stable(act_lat));
  // R6
  busy_keeps_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(act_lat));
endmodule

// File: rtl/lat_pipe.sv
module lat_pipe
  import lat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_vld,
  input  logic [DW-1:0]     rd_data,
  input  logic              mrs_vld,
  input  logic [CODE_W-1:0] mrs_code,
  output logic              dout_vld,
  output logic [DW-1:0]     dout,
  output logic              lat_err
);
  logic [LAT_W-1:0] act_lat;
  logic             s_vld [0:NPIPE];
  logic [DW-1:0]    s_dat [0:NPIPE];
  logic             idle;
  logic             sel_vld;
  logic [DW-1:0]    sel_dat;

  // capture stage: always in the path
  lat_stage #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(1'b1),
    .in_vld(rd_vld), .in_data(rd_data),
    .q_vld(s_vld[0]), .q_data(s_dat[0])
  );

  // holding stage i is in the path when latency exceeds i
  for (genvar i = 1; i <= NPIPE; i++) begin : g_hold
    logic use_stg;
    assign use_stg = (32'(act_lat) > i);
    lat_stage #(.DW(DW)) u_hold (
      .clk(clk), .rst_n(rst_n), .en(use_stg),
      .in_vld(s_vld[i-1]), .in_data(s_dat[i-1]),
      .q_vld(s_vld[i]), .q_data(s_dat[i])
    );
  end

  always_comb begin
    idle = 1'b1;
    for (int k = 0; k <= NPIPE; k++) if (s_vld[k]) idle = 1'b0;
  end

  // bypass selection: output taps the last stage in the path
  always_comb begin
    sel_vld = 1'b0;
    sel_dat = '0;
    for (int k = 0; k <= NPIPE; k++) begin
      if (32'(act_lat) == k + 1) begin
        sel_vld = s_vld[k];
        sel_dat = s_dat[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_vld <= 1'b0;
      dout     <= '0;
    end else begin
      dout_vld <= sel_vld;
      dout     <= sel_vld ? sel_dat : '0;
    end
  end

  lat_cfg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .mrs_vld(mrs_vld), .mrs_code(mrs_code),
    .idle(idle), .act_lat(act_lat), .lat_err(lat_err)
  );

  // R2
  lat1_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld[0] && act_lat == LAT_W'(1)) |=> dout_vld);
  // R2
  lat2_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld[0] && act_lat == LAT_W'(2)) |=> ##1 dout_vld);
  // R2
  lat3_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld[0] && act_lat == LAT_W'(3)) |=> ##2 dout_vld);
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> (dout == '0));
endmodule

// File: tb/test_lat_pipe.sv
module test_lat_pipe;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_vld = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          mrs_vld = 1'b0;
  logic [3:0]    mrs_code = '0;
  logic          dout_vld;
  logic [DW-1:0] dout;
  logic          lat_err;

  lat_pipe #(.DW(DW)) i_lat_pipe (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_data(rd_data),
    .mrs_vld(mrs_vld), .mrs_code(mrs_code),
    .dout_vld(dout_vld), .dout(dout), .lat_err(lat_err)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    logic [DW-1:0] d;
    int            due;
    string         req;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  int model_lat = 3;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_rd(input logic [DW-1:0] d, input string req);
    exp_t e;
    e.d = d; e.due = cyc + 1 + model_lat; e.req = req;
    q.push_back(e);
    rd_vld = 1'b1; rd_data = d;
    @(negedge clk);
    rd_vld = 1'b0; rd_data = '0;
  endtask

  task automatic do_mrs(input logic [3:0] code);
    mrs_vld = 1'b1; mrs_code = code;
    @(negedge clk);
    mrs_vld = 1'b0; mrs_code = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected words as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (dout_vld) begin
        if (q.size() == 0) check(1'b0, "R3", "unexpected valid", int'(dout), 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(dout == e.d, e.req, "data", int'(dout), int'(e.d));
          check(cyc == e.due, e.req, "arrival cycle", cyc, e.due);
        end
      end else begin
        if (dout !== '0) check(1'b0, "R3", "data while not valid", int'(dout), 0);
        if (q.size() != 0 && q[0].due <= cyc) begin
          check(1'b0, q[0].req, "word missing at cycle", cyc, q[0].due);
          void'(q.pop_front());
        end
      end
    end
  end

  task automatic run_all();
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dout_vld == 1'b0, "R1", "dout_vld after reset", int'(dout_vld), 0);
    check(dout == '0, "R1", "dout after reset", int'(dout), 0);
    check(lat_err == 1'b0, "R1", "lat_err after reset", int'(lat_err), 0);
    do_rd(16'hA001, "R1");          // default latency three
    idle(5);
    for (int i = 0; i < 4; i++) do_rd(16'hB300 + 16'(i), "R4");
    idle(6);
    // R2 latency two
    do_mrs(4'd4); model_lat = 2;
    do_rd(16'hC201, "R2");
    idle(4);
    for (int i = 0; i < 3; i++) do_rd(16'hC280 + 16'(i), "R4");
    idle(5);
    // R2 latency one
    do_mrs(4'd2); model_lat = 1;
    do_rd(16'hD101, "R2");
    idle(3);
    for (int i = 0; i < 5; i++) do_rd(16'hD180 + 16'(i), "R4");
    idle(4);
    // R5 unsupported codes
    do_mrs(4'd3);
    check(lat_err == 1'b1, "R5", "lat_err after code 3", int'(lat_err), 1);
    do_rd(16'hE501, "R5");
    idle(3);
    do_mrs(4'd8);
    do_mrs(4'd0);
    do_rd(16'hE502, "R5");
    idle(3);
    do_mrs(4'd6); model_lat = 3;
    check(lat_err == 1'b1, "R5", "lat_err stays after legal code", int'(lat_err), 1);
    do_rd(16'hE503, "R2");
    idle(6);
    // R6 held while busy
    do_rd(16'h6A01, "R6");
    do_mrs(4'd2);
    do_rd(16'h6A02, "R6");          // still latency three
    idle(6);
    model_lat = 1;
    do_rd(16'h6A03, "R6");
    idle(4);
    // R6 later held code replaces earlier one
    do_mrs(4'd6); model_lat = 3;
    do_rd(16'h6B01, "R6");
    do_mrs(4'd4);
    do_mrs(4'd2);
    idle(6);
    model_lat = 1;
    do_rd(16'h6B02, "R6");
    idle(4);
    // R1 reset restores defaults
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    model_lat = 3;
    @(negedge clk);
    check(lat_err == 1'b0, "R1", "lat_err after second reset", int'(lat_err), 0);
    do_rd(16'h1F01, "R1");
    idle(6);
    check(q.size() == 0, "R3", "words never produced", q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule